// File: doc/BRIEF.md
# System Register Store and Trap Unit

This unit executes a narrow slice of a 16-bit instruction set. It covers three groups of instructions. The first copies the multiply-accumulate halves or the procedure register into a general register. The second pushes the same registers, or the status-save, saved-PC or banked registers, onto a stack in memory with pre-decrement addressing. The third is a software trap that saves the program counter and status word and latches an 8-bit trap code.

The unit accepts one instruction word at a time while idle. It reads the base register through a general register file read port and samples every source value on the accepting edge. It then counts out the minimum cycle count for the instruction's class. Stores finish on a valid/ready memory handshake, which can stretch past the minimum when the memory port is busy with instruction fetch. The surrounding core sees a `done` pulse when an instruction retires. An `illegal` pulse means a privileged word arrived in user mode. An `unhandled` pulse means the word is not in this group. A one-cycle `trap_taken` pulse follows the trap.

Top module: `sysst_unit`

## Requirements
- R1: Word `0000nnnn00ss1010` with ss = 00 (MACH), 01 (MACL) or 10 (PR) writes the selected register into Rn. In the first cycle after the accepting edge, `rf_we` and `done` are high and `rf_waddr` = n.
- R2: Word `0100nnnn00ss0010` (same ss selection) works in either mode. It raises `mem_valid` in the first cycle after acceptance, with `mem_addr` = Rn-4 and `mem_wdata` = the selected register. Rn is written with Rn-4 in the cycle the handshake completes.
- R3: Word `0100nnnn xxxx0011` stores a control register at Rn-4 and writes Rn-4 back to Rn. Bits 7:4 select the source: 0011 picks the status-save register, 0100 the saved PC, and 1mmm banked register mmm (presented on `bank_sel`). It is privileged. `mem_valid` is low in the first cycle after acceptance and rises in the second.
- R4: A privileged word accepted with `user_mode` = 1 pulses `illegal` for one cycle, in the first cycle after acceptance. It produces no register write, no memory request and no `done`.
- R5: While `mem_valid` is high and `mem_ready` is low, address and data stay unchanged and `done` stays low. `done` and the base register write-back occur in the cycle `mem_ready` is high.
- R6: Word `11000011iiiiiiii` raises `done` in the eighth cycle after acceptance. In that cycle `spc_we` carries the PC and `ssr_we` carries SR. `tra` then holds the immediate zero-extended to 32 bits.
- R7: `trap_taken` is high for exactly one cycle, the cycle after the trap's `done`.
- R8: Any other word pulses `unhandled` for one cycle and causes no write of any kind. `tra` is left unchanged.
- R9: `issue` is ignored while `busy` is high.
- R10: After reset, `busy`, `done`, `mem_valid`, `trap_taken` are low and `tra` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| user_mode | input | 1 | 1 = user mode, 0 = privileged |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction retires this cycle |
| illegal | output | 1 | Privileged word refused |
| unhandled | output | 1 | Word outside this group |
| rf_raddr | output | 4 | Base register read index |
| rf_rdata | input | 32 | Base register value |
| rf_we | output | 1 | General register write enable |
| rf_waddr | output | 4 | General register write index |
| rf_wdata | output | 32 | General register write data |
| mach_in | input | 32 | MAC high half |
| macl_in | input | 32 | MAC low half |
| pr_in | input | 32 | Procedure register |
| ssr_in | input | 32 | Status-save register |
| spc_in | input | 32 | Saved PC register |
| bank_sel | output | 3 | Banked register index |
| bank_rdata | input | 32 | Selected banked register value |
| pc_in | input | 32 | Current PC |
| sr_in | input | 32 | Current status word |
| ssr_we | output | 1 | Status-save write enable |
| ssr_wdata | output | 32 | Status-save write data |
| spc_we | output | 1 | Saved PC write enable |
| spc_wdata | output | 32 | Saved PC write data |
| tra | output | 32 | Trap code register |
| trap_taken | output | 1 | Trap sequence finished |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
Directed tests cover the cycle each class first raises its outputs. A control-register store that fires its memory request one cycle early would report `mem_valid` in the first cycle and fail. A trap count that is off by one moves `done` off the eighth cycle. Stalled handshakes check that write-back waits for `mem_ready`: a unit that retires early would decrement Rn while memory never saw the data. Privileged words in user mode, near-miss encodings (ss = 11, control field 0101) and words arriving mid-trap all probe the paths where a careless decoder would write a register, start a store or overwrite the trap code.

// File: rtl/sysst_pkg.sv
package sysst_pkg;

    localparam int INSTR_W = 16;
    localparam int RIDX_W  = 4;
    localparam int BANK_W  = 3;
    localparam int IMM_W   = 8;

    typedef enum logic [2:0] {
        K_NONE,
        K_STS_REG,
        K_STS_MEM,
        K_STC_MEM,
        K_TRAP
    } kind_e;

    typedef enum logic [2:0] {
        S_MACH,
        S_MACL,
        S_PR,
        S_SSR,
        S_SPC,
        S_BANK
    } src_e;

    typedef struct packed {
        kind_e              kind;
        src_e               src;
        logic               priv;
        logic [RIDX_W-1:0]  rn;
        logic [BANK_W-1:0]  bank;
        logic [IMM_W-1:0]   imm;
    } dec_t;

    function automatic logic needs_mem(kind_e k);
        return (k == K_STS_MEM) || (k == K_STC_MEM);
    endfunction

    function automatic src_e special_src(logic [1:0] ss);
        case (ss)
            2'b00:   return S_MACH;
            2'b01:   return S_MACL;
            default: return S_PR;
        endcase
    endfunction

endpackage

// File: rtl/sysst_decode.sv
module sysst_decode
    import sysst_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic [3:0] hi_nib;
    logic [3:0] mid_nib;
    logic [3:0] lo_nib;

    assign hi_nib  = instr[15:12];
    assign mid_nib = instr[7:4];
    assign lo_nib  = instr[3:0];

    always_comb begin
        dec      = '0;
        dec.kind = K_NONE;
        dec.src  = S_MACH;
        dec.rn   = instr[11:8];
        dec.bank = instr[6:4];
        dec.imm  = instr[7:0];
        if (instr[15:8] == 8'hC3) begin
            dec.kind = K_TRAP;
        end else if (hi_nib == 4'h0 && lo_nib == 4'hA &&
                     mid_nib[3:2] == 2'b00 && mid_nib[1:0] != 2'b11) begin
            dec.kind = K_STS_REG;
            dec.src  = special_src(mid_nib[1:0]);
        end else if (hi_nib == 4'h4 && lo_nib == 4'h2 &&
                     mid_nib[3:2] == 2'b00 && mid_nib[1:0] != 2'b11) begin
            dec.kind = K_STS_MEM;
            dec.src  = special_src(mid_nib[1:0]);
        end else if (hi_nib == 4'h4 && lo_nib == 4'h3) begin
            dec.priv = 1'b1;
            if (mid_nib[3]) begin
                dec.kind = K_STC_MEM;
                dec.src  = S_BANK;
            end else if (mid_nib == 4'h3) begin
                dec.kind = K_STC_MEM;
                dec.src  = S_SSR;
            end else if (mid_nib == 4'h4) begin
                dec.kind = K_STC_MEM;
                dec.src  = S_SPC;
            end else begin
                dec.priv = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sysst_seq.sv
module sysst_seq
    import sysst_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SPEC_CYC = 1,
    parameter int CTRL_CYC = 2,
    parameter int TRAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              user_mode,
    input  dec_t              dec,
    input  logic [DW-1:0]     rf_rdata,
    input  logic [DW-1:0]     mach_in,
    input  logic [DW-1:0]     macl_in,
    input  logic [DW-1:0]     pr_in,
    input  logic [DW-1:0]     ssr_in,
    input  logic [DW-1:0]     spc_in,
    input  logic [DW-1:0]     bank_rdata,
    input  logic [DW-1:0]     pc_in,
    input  logic [DW-1:0]     sr_in,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              unhandled,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              ssr_we,
    output logic [DW-1:0]     ssr_wdata,
    output logic              spc_we,
    output logic [DW-1:0]     spc_wdata,
    output logic [DW-1:0]     tra,
    output logic              trap_taken,
    output logic              mem_valid,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata
);

    localparam int MAXC = (TRAP_CYC > CTRL_CYC) ? TRAP_CYC : CTRL_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [DW-1:0] STEP = DW'(4);

    typedef enum logic {ST_IDLE, ST_EXEC} state_e;

    state_e             state;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      last_cnt;
    kind_e              op;
    logic [RIDX_W-1:0]  rn_q;
    logic [DW-1:0]      val_q;
    logic [DW-1:0]      addr_q;
    logic [DW-1:0]      pc_q;
    logic [DW-1:0]      sr_q;
    logic [IMM_W-1:0]   imm_q;

    logic [DW-1:0]      src_val;
    logic [CW-1:0]      lat_m1;
    logic               accept;
    logic               refuse;
    logic               go;
    logic               at_last;
    logic               op_mem;
    logic               finish;

    always_comb begin
        case (dec.src)
            S_MACH:  src_val = mach_in;
            S_MACL:  src_val = macl_in;
            S_PR:    src_val = pr_in;
            S_SSR:   src_val = ssr_in;
            S_SPC:   src_val = spc_in;
            default: src_val = bank_rdata;
        endcase
        case (dec.kind)
            K_STC_MEM: lat_m1 = CW'(CTRL_CYC - 1);
            K_TRAP:    lat_m1 = CW'(TRAP_CYC - 1);
            default:   lat_m1 = CW'(SPEC_CYC - 1);
        endcase
    end

    assign accept  = issue && (state == ST_IDLE);
    assign refuse  = dec.priv && user_mode;
    assign go      = accept && (dec.kind != K_NONE) && !refuse;
    assign at_last = (state == ST_EXEC) && (cnt == last_cnt);
    assign op_mem  = needs_mem(op);
    assign finish  = at_last && (!op_mem || mem_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            last_cnt   <= '0;
            op         <= K_NONE;
            rn_q       <= '0;
            val_q      <= '0;
            addr_q     <= '0;
            pc_q       <= '0;
            sr_q       <= '0;
            imm_q      <= '0;
            tra        <= '0;
            trap_taken <= 1'b0;
            illegal    <= 1'b0;
            unhandled  <= 1'b0;
        end else begin
            illegal    <= accept && (dec.kind != K_NONE) && refuse;
            unhandled  <= accept && (dec.kind == K_NONE);
            trap_taken <= finish && (op == K_TRAP);
            if (go) begin
                state    <= ST_EXEC;
                cnt      <= '0;
                last_cnt <= lat_m1;
                op       <= dec.kind;
                rn_q     <= dec.rn;
                val_q    <= src_val;
                addr_q   <= rf_rdata - STEP;
                pc_q     <= pc_in;
                sr_q     <= sr_in;
                imm_q    <= dec.imm;
            end else if (finish) begin
                state <= ST_IDLE;
                if (op == K_TRAP) begin
                    tra <= DW'(imm_q);
                end
            end else if (state == ST_EXEC && !at_last) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy      = (state == ST_EXEC);
    assign done      = finish;
    assign mem_valid = at_last && op_mem;
    assign mem_addr  = addr_q;
    assign mem_wdata = val_q;
    assign rf_we     = finish && ((op == K_STS_REG) || op_mem);
    assign rf_waddr  = rn_q;
    assign rf_wdata  = (op == K_STS_REG) ? val_q : addr_q;
    assign spc_we    = finish && (op == K_TRAP);
    assign spc_wdata = pc_q;
    assign ssr_we    = finish && (op == K_TRAP);
    assign ssr_wdata = sr_q;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R5

    AST_STORE_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |-> (rf_we && done && rf_wdata == mem_addr)); // R2

    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trap_taken |=> !trap_taken); // R7

    AST_TRAP_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> $past(spc_we && ssr_we)); // R6

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, illegal, unhandled})); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rf_we && !mem_valid && !spc_we && !ssr_we)); // R8

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R9

endmodule

// File: rtl/sysst_unit.sv
module sysst_unit
    import sysst_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SPEC_CYC = 1,
    parameter int CTRL_CYC = 2,
    parameter int TRAP_CYC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue,
    input  logic [INSTR_W-1:0] instr,
    input  logic               user_mode,
    output logic               busy,
    output logic               done,
    output logic               illegal,
    output logic               unhandled,
    output logic [RIDX_W-1:0]  rf_raddr,
    input  logic [DW-1:0]      rf_rdata,
    output logic               rf_we,
    output logic [RIDX_W-1:0]  rf_waddr,
    output logic [DW-1:0]      rf_wdata,
    input  logic [DW-1:0]      mach_in,
    input  logic [DW-1:0]      macl_in,
    input  logic [DW-1:0]      pr_in,
    input  logic [DW-1:0]      ssr_in,
    input  logic [DW-1:0]      spc_in,
    output logic [BANK_W-1:0]  bank_sel,
    input  logic [DW-1:0]      bank_rdata,
    input  logic [DW-1:0]      pc_in,
    input  logic [DW-1:0]      sr_in,
    output logic               ssr_we,
    output logic [DW-1:0]      ssr_wdata,
    output logic               spc_we,
    output logic [DW-1:0]      spc_wdata,
    output logic [DW-1:0]      tra,
    output logic               trap_taken,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [DW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata
);

    dec_t dec;

    sysst_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign rf_raddr = dec.rn;
    assign bank_sel = dec.bank;

    sysst_seq #(
        .DW       (DW),
        .SPEC_CYC (SPEC_CYC),
        .CTRL_CYC (CTRL_CYC),
        .TRAP_CYC (TRAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .user_mode  (user_mode),
        .dec        (dec),
        .rf_rdata   (rf_rdata),
        .mach_in    (mach_in),
        .macl_in    (macl_in),
        .pr_in      (pr_in),
        .ssr_in     (ssr_in),
        .spc_in     (spc_in),
        .bank_rdata (bank_rdata),
        .pc_in      (pc_in),
        .sr_in      (sr_in),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .unhandled  (unhandled),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .ssr_we     (ssr_we),
        .ssr_wdata  (ssr_wdata),
        .spc_we     (spc_we),
        .spc_wdata  (spc_wdata),
        .tra        (tra),
        .trap_taken (trap_taken),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

endmodule

// File: tb/sysst_unit_test.sv
`timescale 1ns/1ps
module sysst_unit_test;

    localparam logic [31:0] V_MACH = 32'h1111_0001;
    localparam logic [31:0] V_MACL = 32'h1111_0002;
    localparam logic [31:0] V_PR   = 32'h1111_0003;
    localparam logic [31:0] V_SSR  = 32'h5555_0000;
    localparam logic [31:0] V_SPC  = 32'h6666_0000;
    localparam logic [31:0] V_PC   = 32'h0000_8000;
    localparam logic [31:0] V_SR   = 32'h4000_00F0;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [15:0] instr;
    logic        user_mode;
    logic        busy, done, illegal, unhandled;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic [2:0]  bank_sel;
    logic [31:0] bank_rdata;
    logic        ssr_we, spc_we;
    logic [31:0] ssr_wdata, spc_wdata, tra;
    logic        trap_taken;
    logic        mem_valid, mem_ready;
    logic [31:0] mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign rf_rdata   = 32'h2000_0000 | (32'(rf_raddr) << 8);
    assign bank_rdata = 32'hB000_0000 | 32'(bank_sel);

    sysst_unit uut (
        .clk(clk), .rst(rst), .issue(issue), .instr(instr), .user_mode(user_mode),
        .busy(busy), .done(done), .illegal(illegal), .unhandled(unhandled),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mach_in(V_MACH), .macl_in(V_MACL), .pr_in(V_PR),
        .ssr_in(V_SSR), .spc_in(V_SPC),
        .bank_sel(bank_sel), .bank_rdata(bank_rdata),
        .pc_in(V_PC), .sr_in(V_SR),
        .ssr_we(ssr_we), .ssr_wdata(ssr_wdata), .spc_we(spc_we), .spc_wdata(spc_wdata),
        .tra(tra), .trap_taken(trap_taken),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] base_of(input logic [3:0] n);
        return 32'h2000_0000 | (32'(n) << 8);
    endfunction

    function automatic logic [31:0] spec_val(input logic [1:0] ss);
        case (ss)
            2'b00:   return V_MACH;
            2'b01:   return V_MACL;
            default: return V_PR;
        endcase
    endfunction

    // Leaves the caller at the falling edge of the first cycle after acceptance.
    task automatic issue_word(input logic [15:0] w, input logic um);
        @(negedge clk);
        instr = w; user_mode = um; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        chk("R10", "busy", 32'(busy), 0);
        chk("R10", "done", 32'(done), 0);
        chk("R10", "mem_valid", 32'(mem_valid), 0);
        chk("R10", "trap_taken", 32'(trap_taken), 0);
        chk("R10", "tra", tra, 0);
    endtask

    task automatic t_sts_reg(input logic [1:0] ss, input logic [3:0] n);
        mem_ready = 1'b1;
        issue_word({4'h0, n, 2'b00, ss, 4'hA}, 1'b1);
        chk("R1", "rf_we", 32'(rf_we), 1);
        chk("R1", "done", 32'(done), 1);
        chk("R1", "rf_waddr", 32'(rf_waddr), 32'(n));
        chk("R1", "rf_wdata", rf_wdata, spec_val(ss));
        chk("R1", "mem_valid", 32'(mem_valid), 0);
        @(negedge clk); #1;
        chk("R1", "busy after", 32'(busy), 0);
    endtask

    task automatic t_sts_mem(input logic [1:0] ss, input logic [3:0] n);
        mem_ready = 1'b1;
        issue_word({4'h4, n, 2'b00, ss, 4'h2}, 1'b1);
        chk("R2", "mem_valid", 32'(mem_valid), 1);
        chk("R2", "mem_addr", mem_addr, base_of(n) - 32'd4);
        chk("R2", "mem_wdata", mem_wdata, spec_val(ss));
        chk("R2", "rf_we", 32'(rf_we), 1);
        chk("R2", "rf_waddr", 32'(rf_waddr), 32'(n));
        chk("R2", "rf_wdata", rf_wdata, base_of(n) - 32'd4);
        chk("R2", "done", 32'(done), 1);
    endtask

    task automatic t_stc(input logic [3:0] sel, input logic [3:0] n,
                         input logic [31:0] expv, input int stall);
        mem_ready = (stall == 0);
        issue_word({4'h4, n, sel, 4'h3}, 1'b0);
        chk("R3", "mem_valid cycle1", 32'(mem_valid), 0);
        chk("R3", "done cycle1", 32'(done), 0);
        chk("R3", "busy cycle1", 32'(busy), 1);
        @(negedge clk); #1;
        chk("R3", "mem_valid cycle2", 32'(mem_valid), 1);
        chk("R3", "mem_addr", mem_addr, base_of(n) - 32'd4);
        chk("R3", "mem_wdata", mem_wdata, expv);
        for (int i = 0; i < stall; i++) begin
            chk("R5", "done during stall", 32'(done), 0);
            chk("R5", "rf_we during stall", 32'(rf_we), 0);
            chk("R5", "valid held", 32'(mem_valid), 1);
            chk("R5", "addr held", mem_addr, base_of(n) - 32'd4);
            chk("R5", "data held", mem_wdata, expv);
            @(negedge clk); #1;
        end
        mem_ready = 1'b1;
        #1;
        chk("R5", "done on ready", 32'(done), 1);
        chk("R5", "rf_we on ready", 32'(rf_we), 1);
        chk("R3", "rf_wdata", rf_wdata, base_of(n) - 32'd4);
        @(negedge clk); #1;
        chk("R5", "idle after", 32'(busy), 0);
    endtask

    task automatic t_illegal(input logic [15:0] w);
        mem_ready = 1'b1;
        issue_word(w, 1'b1);
        chk("R4", "illegal", 32'(illegal), 1);
        chk("R4", "busy", 32'(busy), 0);
        for (int k = 0; k < 3; k++) begin
            chk("R4", "rf_we", 32'(rf_we), 0);
            chk("R4", "mem_valid", 32'(mem_valid), 0);
            chk("R4", "done", 32'(done), 0);
            @(negedge clk); #1;
            chk("R4", "illegal one cycle", 32'(illegal), 0);
        end
    endtask

    task automatic t_trap(input logic [7:0] imm, input logic busy_probe);
        issue_word({8'hC3, imm}, 1'b1);
        for (int k = 1; k <= 8; k++) begin
            if (busy_probe && k < 7) begin
                instr = 16'h0A0A; issue = 1'b1;
                #1;
            end else begin
                issue = 1'b0;
            end
            if (k < 8) begin
                chk("R6", "done early", 32'(done), 0);
                chk("R9", "no write while busy", 32'(rf_we), 0);
                chk("R9", "busy held", 32'(busy), 1);
                @(negedge clk); #1;
            end else begin
                chk("R6", "done cycle8", 32'(done), 1);
                chk("R6", "spc_we", 32'(spc_we), 1);
                chk("R6", "spc_wdata", spc_wdata, V_PC);
                chk("R6", "ssr_we", 32'(ssr_we), 1);
                chk("R6", "ssr_wdata", ssr_wdata, V_SR);
                chk("R7", "trap_taken not yet", 32'(trap_taken), 0);
            end
        end
        @(negedge clk); #1;
        chk("R7", "trap_taken", 32'(trap_taken), 1);
        chk("R6", "tra", tra, {24'h0, imm});
        chk("R9", "no late accept", 32'(busy), 0);
        @(negedge clk); #1;
        chk("R7", "trap_taken one cycle", 32'(trap_taken), 0);
    endtask

    task automatic t_unhandled(input logic [15:0] w);
        logic [31:0] tra_before;
        tra_before = tra;
        issue_word(w, 1'b0);
        chk("R8", "unhandled", 32'(unhandled), 1);
        chk("R8", "busy", 32'(busy), 0);
        chk("R8", "rf_we", 32'(rf_we), 0);
        chk("R8", "mem_valid", 32'(mem_valid), 0);
        @(negedge clk); #1;
        chk("R8", "unhandled one cycle", 32'(unhandled), 0);
        chk("R8", "done", 32'(done), 0);
        chk("R8", "tra kept", tra, tra_before);
    endtask

    initial begin
        rst = 1'b1; issue = 1'b0; instr = '0; user_mode = 1'b0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_sts_reg(2'b00, 4'd3);
        t_sts_reg(2'b01, 4'd0);
        t_sts_reg(2'b10, 4'd15);
        t_sts_mem(2'b00, 4'd7);
        t_sts_mem(2'b10, 4'd1);
        t_stc(4'h3, 4'd2, V_SSR, 0);
        t_stc(4'h4, 4'd9, V_SPC, 2);
        t_stc(4'hD, 4'd4, 32'hB000_0005, 0);
        t_stc(4'h8, 4'd15, 32'hB000_0000, 1);
        t_illegal(16'h4283);
        t_illegal(16'h4133);
        t_trap(8'hA5, 1'b0);
        t_unhandled(16'h013A);
        t_unhandled(16'h4153);
        t_unhandled(16'h4132);
        t_unhandled(16'hFFFF);
        t_trap(8'h5A, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule